// File: doc/BRIEF.md
# Fill-Pattern DMA Channel

This block is a single DMA channel that initialises a memory region with a constant pattern. Software loads a fill word, a start address, a signed address step, a transfer size, a byte total, a gap length and a few control bits, then pulses `start`. The channel never reads a source. It drives the same fill word to a sequence of addresses through a valid/ready write port until the byte total is used up.

The cycle after `start`, the channel checks the captured settings against the rules for single-address fill operation. A bad setting raises a sticky configuration-error flag, and the channel stays idle with no bus activity. A legal setting moves the channel to its running state. In that state it issues one write per request and waits a programmable number of idle cycles after each accepted write before it asks again. When the last write is accepted it clears `busy` and raises `done`.

Top module: `fill_dma_channel`

## Requirements
- R1: While reset is held and in the first cycle after it, `busy`, `done`, `cfg_err` and `bus_valid` are all low.
- R2: A fill run needs `cfg_ext_req`=0, `cfg_single`=1 and `cfg_to_mem`=1. Any other combination is a configuration error.
- R3: With `cfg_burst`=1 the step must be +4 or −4 (two's complement in `cfg_incr`). Any other value is a configuration error. With `cfg_burst`=0 any nonzero step is accepted.
- R4: A step of zero is a configuration error in every fill setting, burst or not.
- R5: `cfg_size` codes are 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, and code 3 is a configuration error. With a negative step, a 2-byte size needs start-address bit 0 set, and a 4-byte size needs start-address bits 1:0 both set. Otherwise it is a configuration error.
- R6: The byte total must be nonzero and a whole multiple of the transfer size. Otherwise it is a configuration error.
- R7: After a `start` with bad settings, `cfg_err` goes high at the second rising edge. `busy` and `bus_valid` stay low throughout. `cfg_err` stays high until `err_clear` is sampled high, which clears it at that edge.
- R8: After a `start` with legal settings, `busy` goes high at the second rising edge. Write k (counting from 0) carries `cfg_fill` on `bus_data` and `cfg_size` on `bus_size`. Its `bus_addr` is start + k·step with the low log2(size) bits forced to zero.
- R9: While `bus_valid` is high and `bus_ready` is low, `bus_valid`, `bus_addr` and `bus_data` do not change.
- R10: After each accepted write that is not the last, `bus_valid` stays low for exactly `cfg_gap` cycles before the next request. A gap of 0 gives back-to-back requests.
- R11: Each accepted write uses up one transfer size of the byte total. The edge that accepts the final write clears `busy` and sets `done`. `done` is cleared by the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Starts a run when the channel is idle; the settings are captured here |
| err_clear | input | 1 | Clears the configuration-error flag |
| cfg_ext_req | input | 1 | External request select (must be 0) |
| cfg_single | input | 1 | Single-address select (must be 1) |
| cfg_to_mem | input | 1 | Direction, device to memory (must be 1) |
| cfg_burst | input | 1 | Burst operation; limits the step to ±4 |
| cfg_size | input | 2 | Transfer size code |
| cfg_incr | input | INC_W | Signed address step per write |
| cfg_gap | input | GAP_W | Idle cycles between requests |
| cfg_count | input | CNT_W | Byte total of the run |
| cfg_addr | input | ADDR_W | Start address |
| cfg_fill | input | DATA_W | Fill word |
| bus_valid | output | 1 | Write request valid |
| bus_ready | input | 1 | Write request accepted |
| bus_addr | output | ADDR_W | Write address, aligned to the size |
| bus_data | output | DATA_W | Write data (the fill word) |
| bus_size | output | 2 | Write size code |
| busy | output | 1 | Run in progress |
| done | output | 1 | Last run finished |
| cfg_err | output | 1 | Sticky configuration-error flag |

## Verification
The hardest case to reach is the meeting of a stalled write, a nonzero gap and a negative step on a multi-byte size. Here the hold rule, the gap count and the alignment of a descending address all act on the same request. The stimulus sweeps every size, both step signs, burst and non-burst steps, several gap lengths, and a ready pattern that drops for one cycle in three. The gap count is therefore checked both after stalled accepts and after immediate ones. A second sweep breaks one rule at a time and watches the bus stay quiet.

// File: rtl/fill_dma_pkg.sv
package fill_dma_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_BAD  = 2'd3
   } xfer_size_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_CHECK = 2'd1,
      ST_RUN   = 2'd2
   } chan_state_e;

   function automatic logic [2:0] size_bytes(input logic [1:0] code);
      case (code)
         SZ_BYTE: return 3'd1;
         SZ_HALF: return 3'd2;
         SZ_WORD: return 3'd4;
         default: return 3'd0;
      endcase
   endfunction

   function automatic logic [1:0] low_mask(input logic [1:0] code);
      case (code)
         SZ_HALF: return 2'b10;
         SZ_WORD: return 2'b00;
         default: return 2'b11;
      endcase
   endfunction

endpackage

// File: rtl/fill_cfg_check.sv
module fill_cfg_check import fill_dma_pkg::*; #(
   parameter int INC_W = 8,
   parameter int CNT_W = 16
) (
   input  logic             ext_req,
   input  logic             single,
   input  logic             to_mem,
   input  logic             burst,
   input  logic [1:0]       size,
   input  logic [INC_W-1:0] incr,
   input  logic [1:0]       addr_lo,
   input  logic [CNT_W-1:0] count,
   output logic             legal
);
   localparam logic [INC_W-1:0] STEP_UP   = INC_W'(4);
   localparam logic [INC_W-1:0] STEP_DOWN = ~STEP_UP + 1'b1;

   logic mode_ok, size_ok, step_ok, burst_ok, align_ok, count_ok, negative;

   assign negative = incr[INC_W-1];
   assign mode_ok  = !ext_req && single && to_mem;
   assign size_ok  = (size != SZ_BAD);
   assign step_ok  = (incr != '0);
   assign burst_ok = !burst || (incr == STEP_UP) || (incr == STEP_DOWN);

   always_comb begin
      align_ok = 1'b1;
      count_ok = (count != '0);
      case (size)
         SZ_HALF: begin
            if (negative) align_ok = addr_lo[0];
            if (count[0]) count_ok = 1'b0;
         end
         SZ_WORD: begin
            if (negative) align_ok = &addr_lo;
            if (count[1:0] != 2'b00) count_ok = 1'b0;
         end
         default: ;
      endcase
   end

   assign legal = mode_ok && size_ok && step_ok && burst_ok && align_ok && count_ok;

endmodule

// File: rtl/fill_gap_timer.sv
module fill_gap_timer #(
   parameter int GAP_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [GAP_W-1:0] gap,
   output logic             idle
);
   logic [GAP_W-1:0] remain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              remain <= '0;
      else if (load)           remain <= gap;
      else if (remain != '0)   remain <= remain - 1'b1;
   end

   assign idle = (remain == '0);

endmodule

// File: rtl/fill_addr_gen.sv
module fill_addr_gen import fill_dma_pkg::*; #(
   parameter int ADDR_W = 32,
   parameter int INC_W  = 8,
   parameter int CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              step,
   input  logic [ADDR_W-1:0] load_addr,
   input  logic [CNT_W-1:0]  load_count,
   input  logic [INC_W-1:0]  incr,
   input  logic [1:0]        size,
   output logic [ADDR_W-1:0] cur_addr,
   output logic [CNT_W-1:0]  remaining,
   output logic              last
);
   localparam int EXT_W = ADDR_W - INC_W;

   logic [ADDR_W-1:0] step_ext;
   logic [CNT_W-1:0]  unit;

   assign step_ext = {{EXT_W{incr[INC_W-1]}}, incr};
   assign unit     = CNT_W'(size_bytes(size));
   assign last     = (remaining == unit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_addr  <= '0;
         remaining <= '0;
      end else if (load) begin
         cur_addr  <= load_addr;
         remaining <= load_count;
      end else if (step) begin
         cur_addr  <= cur_addr + step_ext;
         remaining <= remaining - unit;
      end
   end

endmodule

// File: rtl/fill_dma_channel.sv
module fill_dma_channel import fill_dma_pkg::*; #(
   parameter int ADDR_W    = 32,
   parameter int DATA_W    = 32,
   parameter int INC_W     = 8,
   parameter int CNT_W     = 16,
   parameter int GAP_W     = 4,
   parameter bit ALIGN_OUT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              err_clear,
   input  logic              cfg_ext_req,
   input  logic              cfg_single,
   input  logic              cfg_to_mem,
   input  logic              cfg_burst,
   input  logic [1:0]        cfg_size,
   input  logic [INC_W-1:0]  cfg_incr,
   input  logic [GAP_W-1:0]  cfg_gap,
   input  logic [CNT_W-1:0]  cfg_count,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic [DATA_W-1:0] cfg_fill,
   output logic              bus_valid,
   input  logic              bus_ready,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_data,
   output logic [1:0]        bus_size,
   output logic              busy,
   output logic              done,
   output logic              cfg_err
);
   generate
      if (INC_W < 4)       $error("INC_W must hold a signed step of 4");
      if (ADDR_W <= INC_W) $error("ADDR_W must exceed INC_W");
      if (CNT_W < 3)       $error("CNT_W must hold a 4-byte total");
      if (GAP_W < 1)       $error("GAP_W must be at least 1");
      if (DATA_W < 8)      $error("DATA_W must be at least one byte");
   endgenerate

   chan_state_e       state;
   logic              ext_q, single_q, to_mem_q, burst_q;
   logic [1:0]        size_q;
   logic [INC_W-1:0]  incr_q;
   logic [GAP_W-1:0]  gap_q;
   logic [DATA_W-1:0] fill_q;
   logic [ADDR_W-1:0] cur_addr;
   logic [CNT_W-1:0]  remaining;
   logic              legal, last, gap_idle, start_ok, accept;

   assign start_ok  = start && (state == ST_IDLE);
   assign bus_valid = (state == ST_RUN) && gap_idle;
   assign accept    = bus_valid && bus_ready;
   assign busy      = (state == ST_RUN);
   assign bus_data  = fill_q;
   assign bus_size  = size_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ext_q    <= 1'b0;
         single_q <= 1'b0;
         to_mem_q <= 1'b0;
         burst_q  <= 1'b0;
         size_q   <= SZ_BYTE;
         incr_q   <= '0;
         gap_q    <= '0;
         fill_q   <= '0;
      end else if (start_ok) begin
         ext_q    <= cfg_ext_req;
         single_q <= cfg_single;
         to_mem_q <= cfg_to_mem;
         burst_q  <= cfg_burst;
         size_q   <= cfg_size;
         incr_q   <= cfg_incr;
         gap_q    <= cfg_gap;
         fill_q   <= cfg_fill;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
      end else begin
         case (state)
            ST_IDLE:  if (start_ok) state <= ST_CHECK;
            ST_CHECK: state <= legal ? ST_RUN : ST_IDLE;
            ST_RUN:   if (accept && last) state <= ST_IDLE;
            default:  state <= ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   done <= 1'b0;
      else if (start_ok)            done <= 1'b0;
      else if (accept && last)      done <= 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                cfg_err <= 1'b0;
      else if (err_clear)                        cfg_err <= 1'b0;
      else if ((state == ST_CHECK) && !legal)    cfg_err <= 1'b1;
   end

   fill_cfg_check #(.INC_W(INC_W), .CNT_W(CNT_W)) u_check (
      .ext_req (ext_q),
      .single  (single_q),
      .to_mem  (to_mem_q),
      .burst   (burst_q),
      .size    (size_q),
      .incr    (incr_q),
      .addr_lo (cur_addr[1:0]),
      .count   (remaining),
      .legal   (legal)
   );

   fill_addr_gen #(.ADDR_W(ADDR_W), .INC_W(INC_W), .CNT_W(CNT_W)) u_addr (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (start_ok),
      .step       (accept),
      .load_addr  (cfg_addr),
      .load_count (cfg_count),
      .incr       (incr_q),
      .size       (size_q),
      .cur_addr   (cur_addr),
      .remaining  (remaining),
      .last       (last)
   );

   fill_gap_timer #(.GAP_W(GAP_W)) u_gap (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (accept && !last),
      .gap   (gap_q),
      .idle  (gap_idle)
   );

   generate
      if (ALIGN_OUT) begin : g_align
         assign bus_addr = {cur_addr[ADDR_W-1:2], cur_addr[1:0] & low_mask(size_q)};
      end else begin : g_raw
         assign bus_addr = cur_addr;
      end
   endgenerate

endmodule

// File: rtl/fill_dma_checker.sv
module fill_dma_checker #(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int GAP_W  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              done,
   input logic              cfg_err,
   input logic              err_clear,
   input logic              bus_valid,
   input logic              bus_ready,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_data,
   input logic [GAP_W-1:0]  gap_q
);
   assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      bus_valid && !bus_ready |=> bus_valid && $stable(bus_addr) && $stable(bus_data));

   assert_err_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cfg_err) |-> !busy && !$past(busy));

   assert_err_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      err_clear |=> !cfg_err);

   assert_valid_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
      bus_valid |-> busy);

   assert_gap_R10: assert property (@(posedge clk) disable iff (!rst_n)
      bus_valid && bus_ready && busy && gap_q != '0 |=> !bus_valid);

   assert_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> $fell(busy));

endmodule

bind fill_dma_channel fill_dma_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .GAP_W(GAP_W)) u_fill_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .busy      (busy),
   .done      (done),
   .cfg_err   (cfg_err),
   .err_clear (err_clear),
   .bus_valid (bus_valid),
   .bus_ready (bus_ready),
   .bus_addr  (bus_addr),
   .bus_data  (bus_data),
   .gap_q     (gap_q)
);

// File: tb/fill_dma_channel_test.sv
`timescale 1ns/1ps
module fill_dma_channel_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0, err_clear = 1'b0;
   logic        cfg_ext_req, cfg_single, cfg_to_mem, cfg_burst;
   logic [1:0]  cfg_size;
   logic [7:0]  cfg_incr;
   logic [3:0]  cfg_gap;
   logic [15:0] cfg_count;
   logic [31:0] cfg_addr, cfg_fill;
   logic        bus_valid, bus_ready = 1'b1;
   logic [31:0] bus_addr, bus_data;
   logic [1:0]  bus_size;
   logic        busy, done, cfg_err;
   int          n_chk = 0, n_fail = 0;

   always #2.5 clk = ~clk;

   fill_dma_channel uut (
      .clk(clk), .rst_n(rst_n), .start(start), .err_clear(err_clear),
      .cfg_ext_req(cfg_ext_req), .cfg_single(cfg_single), .cfg_to_mem(cfg_to_mem),
      .cfg_burst(cfg_burst), .cfg_size(cfg_size), .cfg_incr(cfg_incr), .cfg_gap(cfg_gap),
      .cfg_count(cfg_count), .cfg_addr(cfg_addr), .cfg_fill(cfg_fill),
      .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_addr(bus_addr),
      .bus_data(bus_data), .bus_size(bus_size), .busy(busy), .done(done), .cfg_err(cfg_err)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   task automatic legal_defaults();
      cfg_ext_req = 1'b0; cfg_single = 1'b1; cfg_to_mem = 1'b1; cfg_burst = 1'b1;
      cfg_size = 2'd2; cfg_incr = 8'd4; cfg_gap = 4'd0; cfg_count = 16'd8;
      cfg_addr = 32'h0000_0100; cfg_fill = 32'hA5C3_0F1E;
   endtask

   task automatic pulse_start();
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic run_bad(input string req);
      int quiet;
      quiet = 1;
      pulse_start();
      check(cfg_err == 1'b0 && busy == 1'b0, req, "flags during check cycle", {cfg_err, busy}, 0);
      @(negedge clk);
      check(cfg_err == 1'b1, req, "cfg_err after bad start", cfg_err, 1);
      check(busy == 1'b0, "R7", "busy after bad start", busy, 0);
      for (int i = 0; i < 4; i++) begin
         if (bus_valid || busy) quiet = 0;
         @(negedge clk);
      end
      check(quiet == 1, "R7", "bus quiet after bad start", quiet, 1);
      check(cfg_err == 1'b1, "R7", "cfg_err sticky", cfg_err, 1);
      err_clear = 1'b1;
      @(negedge clk);
      err_clear = 1'b0;
      check(cfg_err == 1'b0, "R7", "cfg_err after clear", cfg_err, 0);
   endtask

   task automatic run_legal(input int sz, input int stall);
      logic [31:0] cur, expa, mask;
      int nwr, k, idle, guard, pend, hold;
      logic [31:0] held;
      cur = cfg_addr; nwr = int'(cfg_count) / sz; k = 0; idle = 0; guard = 0;
      pend = 0; hold = 0; held = '0;
      mask = ~(32'(sz) - 32'd1);
      pulse_start();
      check(busy == 1'b0 && done == 1'b0, "R11", "busy/done in check cycle", {busy, done}, 0);
      @(negedge clk);
      check(busy == 1'b1 && cfg_err == 1'b0, "R8", "busy after legal start", {busy, cfg_err}, 2);
      while (k < nwr && guard < 2000) begin
         bus_ready = (stall != 0) ? (guard % 3 != 0) : 1'b1;
         if (bus_valid) begin
            if (pend != 0) begin
               check(idle == int'(cfg_gap), "R10", "idle cycles between requests", idle, cfg_gap);
               pend = 0;
            end
            if (hold != 0)
               check(bus_addr == held, "R9", "address held under stall", bus_addr, held);
            if (bus_ready) begin
               expa = cur & mask;
               check(bus_addr == expa, "R8", "write address", bus_addr, expa);
               check(bus_data == cfg_fill && bus_size == cfg_size, "R8", "write data/size",
                     bus_data, cfg_fill);
               cur = cur + {{24{cfg_incr[7]}}, cfg_incr};
               k++; idle = 0; hold = 0;
               pend = (k < nwr) ? 1 : 0;
            end else begin
               hold = 1; held = bus_addr;
            end
         end else if (pend != 0) begin
            idle++;
         end
         @(negedge clk);
         guard++;
      end
      bus_ready = 1'b1;
      check(k == nwr, "R11", "write count", k, nwr);
      check(busy == 1'b0 && done == 1'b1 && bus_valid == 1'b0, "R11", "end flags",
            {busy, done, bus_valid}, 2);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      legal_defaults();
      repeat (3) @(negedge clk);
      check({busy, done, cfg_err, bus_valid} == 4'b0, "R1", "outputs in reset",
            {busy, done, cfg_err, bus_valid}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check({busy, done, cfg_err, bus_valid} == 4'b0, "R1", "outputs after reset",
            {busy, done, cfg_err, bus_valid}, 0);

      // legal sweep: size x burst x sign x gap x stall
      for (int s = 0; s < 3; s++) begin
         for (int b = 0; b < 2; b++) begin
            for (int ng = 0; ng < 2; ng++) begin
               for (int g = 0; g < 3; g++) begin
                  for (int st = 0; st < 2; st++) begin
                     int sz;
                     sz = 1 << s;
                     legal_defaults();
                     cfg_size = 2'(s);
                     cfg_burst = 1'(b);
                     cfg_gap = (g == 0) ? 4'd0 : (g == 1) ? 4'd1 : 4'd3;
                     if (b != 0) cfg_incr = (ng != 0) ? 8'hFC : 8'd4;
                     else        cfg_incr = (ng != 0) ? 8'hFD : 8'd5;
                     cfg_addr = (ng != 0) ? (32'h200 | 32'(sz - 1)) : 32'h103;
                     cfg_count = 16'((2 + g) * sz);
                     cfg_fill = 32'h1000_0000 + 32'(s * 64 + b * 16 + ng * 8 + g * 2 + st);
                     run_legal(sz, st);
                  end
               end
            end
         end
      end

      // error sweep: one rule broken at a time
      legal_defaults(); cfg_ext_req = 1'b1;             run_bad("R2");
      legal_defaults(); cfg_single = 1'b0;              run_bad("R2");
      legal_defaults(); cfg_to_mem = 1'b0;              run_bad("R2");
      legal_defaults(); cfg_incr = 8'd8;                run_bad("R3");
      legal_defaults(); cfg_incr = 8'hFE;               run_bad("R3");
      legal_defaults(); cfg_incr = 8'd0;                run_bad("R4");
      legal_defaults(); cfg_burst = 1'b0; cfg_incr = 8'd0; run_bad("R4");
      legal_defaults(); cfg_size = 2'd3;                run_bad("R5");
      legal_defaults(); cfg_size = 2'd1; cfg_incr = 8'hFC; cfg_addr = 32'h202; run_bad("R5");
      legal_defaults(); cfg_incr = 8'hFC; cfg_addr = 32'h201; run_bad("R5");
      legal_defaults(); cfg_incr = 8'hFC; cfg_addr = 32'h202; run_bad("R5");
      legal_defaults(); cfg_count = 16'd0;              run_bad("R6");
      legal_defaults(); cfg_count = 16'd6;              run_bad("R6");
      legal_defaults(); cfg_size = 2'd1; cfg_count = 16'd5; run_bad("R6");

      // a legal run after the error sweep still works (R8, R11)
      legal_defaults(); cfg_gap = 4'd2; cfg_count = 16'd12;
      run_legal(4, 1);

      summary();
      $finish;
   end
endmodule